// File: doc/BRIEF.md
# Power-Fail Write Protect Controller

This block sits between a host and a battery-backed byte-wide memory. It watches a digital power-good flag from an external supply comparator and decides whether host control strobes may reach the memory. When the supply drops, it deselects the memory, blocks writes and stops the memory from driving its data bus, whatever the host strobes do. When the supply comes back, it holds an active-low reset for a programmed number of reference clock cycles before it lets accesses through again.

The power-good flag is asynchronous and passes through a two-flop synchronizer. Protection starts combinationally from the synchronized flag, with an optional delay that models late protection on a fast supply collapse. Only the release of protection goes through the recovery counter. The recovery length is a parameter in reference clock cycles and should be set to between 40 ms and 200 ms of clock time. A drop of power-good during recovery restarts the count.

Top module: `pfwp_ctrl`

## Requirements
- R1: While rst_ni is low, sys_rst_no is low and mem_sel_o, wr_en_o and drive_en_o are all low, whatever the host inputs are.
- R2: While sys_rst_no is low, mem_sel_o, wr_en_o and drive_en_o stay low for every combination of mem_sel_i, wr_en_i and rd_en_i.
- R3: pwr_good_i reaches the control logic through two clock edges of synchronization. A change made between edges is first acted on at the second rising edge after it.
- R4: After pwr_good_i rises while protected, sys_rst_no goes high at rising edge 2 + REC_CYC counted from the change, and not earlier.
- R5: While sys_rst_no is high, mem_sel_o equals mem_sel_i, wr_en_o equals wr_en_i, and drive_en_o is high exactly when mem_sel_i and rd_en_i are high and wr_en_i is low.
- R6: After pwr_good_i falls, protection engages at rising edge 2 + DROP_DLY_CYC counted from the change. With DROP_DLY_CYC = 0 it engages at the second edge.
- R7: If pwr_good_i drops long enough to engage protection during a recovery count, sys_rst_no stays low. The count restarts, so release comes 2 + REC_CYC edges after the final rise.
- R8: Protection needs no lead time on the host strobes. Strobes held active while power fails are cut in the same cycle that protection engages.
- R9: A low pulse on pwr_good_i that keeps the synchronized flag low for no more than DROP_DLY_CYC cycles does not engage protection when DROP_DLY_CYC > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pwr_good_i | input | 1 | Asynchronous supply-good flag, high when supply is above trip level |
| mem_sel_i | input | 1 | Host memory select, active high |
| wr_en_i | input | 1 | Host write strobe, active high |
| rd_en_i | input | 1 | Host output enable, active high |
| mem_sel_o | output | 1 | Gated memory select |
| wr_en_o | output | 1 | Gated write strobe |
| drive_en_o | output | 1 | Memory data-bus drive enable; low means high impedance |
| sys_rst_no | output | 1 | Active-low reset, low while protected or recovering |

## Verification
A stuck or miscounted recovery counter shows as sys_rst_no rising one or more edges away from 2 + REC_CYC after power-good returns, so the bench samples the edge before and the edge of release. A drop filter that is wrong shows as protection engaging one edge early or late after a fall, or as a short dip reaching the outputs. A counter that is not cleared on a dip during recovery shows as an early release within REC_CYC cycles of the final rise. Any gating error appears at once on the strobe outputs, in the cycle the host drives the combination.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } mem_ctl_t;
endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfwp_drop_filter.sv
module pfwp_drop_filter #(
  parameter int unsigned DROP_DLY_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_sync_i,
  output logic pg_eff_o
);
  if (DROP_DLY_CYC == 0) begin : g_direct
    assign pg_eff_o = pg_sync_i;
  end else begin : g_delay
    localparam int unsigned CW = $clog2(DROP_DLY_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DROP_DLY_CYC);
    logic [CW-1:0] low_cnt_q;

    // reset value LIMIT: start protected
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              low_cnt_q <= LIMIT;
      else if (pg_sync_i)       low_cnt_q <= '0;
      else if (low_cnt_q != LIMIT) low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign pg_eff_o = pg_sync_i | (low_cnt_q != LIMIT);

    a_r6_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_cnt_q <= LIMIT);
    a_r6_fall_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pg_eff_o) |-> $past(!pg_sync_i));
  end
endmodule

// File: rtl/pfwp_recovery.sv
module pfwp_recovery #(
  parameter int unsigned REC_CYC = 4000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_eff_i,
  output logic rec_done_o
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(REC_CYC);
  logic [CW-1:0] rec_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rec_cnt_q <= '0;
    else if (!pg_eff_i)         rec_cnt_q <= '0;
    else if (rec_cnt_q != LIMIT) rec_cnt_q <= rec_cnt_q + 1'b1;
  end

  assign rec_done_o = (rec_cnt_q == LIMIT);

  a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_cnt_q <= LIMIT);
  a_r4_done_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rec_done_o) |-> $past(pg_eff_i));
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_eff_i |=> !rec_done_o);
endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate
  import pfwp_pkg::*;
(
  input  mem_ctl_t host_i,
  input  logic     protect_i,
  output logic     sel_o,
  output logic     wr_o,
  output logic     drive_o
);
  always_comb begin
    sel_o   = host_i.sel & ~protect_i;
    wr_o    = host_i.wr  & ~protect_i;
    // write wins over read: never drive during a write
    drive_o = host_i.sel & host_i.rd & ~host_i.wr & ~protect_i;
  end
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
  import pfwp_pkg::*;
#(
  parameter int unsigned REC_CYC      = 4000000,
  parameter int unsigned DROP_DLY_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic mem_sel_i,
  input  logic wr_en_i,
  input  logic rd_en_i,
  output logic mem_sel_o,
  output logic wr_en_o,
  output logic drive_en_o,
  output logic sys_rst_no
);
  logic     pg_sync, pg_eff, rec_done, protect;
  mem_ctl_t host;

  pfwp_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .d_i(pwr_good_i), .q_o(pg_sync)
  );

  pfwp_drop_filter #(.DROP_DLY_CYC(DROP_DLY_CYC)) i_filter (
    .clk_i, .rst_ni, .pg_sync_i(pg_sync), .pg_eff_o(pg_eff)
  );

  pfwp_recovery #(.REC_CYC(REC_CYC)) i_recovery (
    .clk_i, .rst_ni, .pg_eff_i(pg_eff), .rec_done_o(rec_done)
  );

  // engage is combinational on pg_eff; release waits for the counter
  assign protect    = ~rst_ni | ~pg_eff | ~rec_done;
  assign sys_rst_no = ~protect;
  assign host       = '{sel: mem_sel_i, wr: wr_en_i, rd: rd_en_i};

  pfwp_gate i_gate (
    .host_i(host), .protect_i(protect),
    .sel_o(mem_sel_o), .wr_o(wr_en_o), .drive_o(drive_en_o)
  );

  a_r2_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !(mem_sel_o | wr_en_o | drive_en_o));
  a_r5_pass_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no |-> (mem_sel_o == mem_sel_i) && (wr_en_o == wr_en_i));
  a_r5_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !drive_en_o);
  a_r7_no_release_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_eff) |-> !sys_rst_no);
endmodule

// File: tb/test_pfwp_ctrl.sv
`timescale 1ns/1ps
module test_pfwp_ctrl;
  localparam int unsigned REC = 40;
  localparam int unsigned DLY = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b0;
  logic mem_sel_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic a_sel, a_wr, a_drv, a_rst;
  logic b_sel, b_wr, b_drv, b_rst;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pfwp_ctrl #(.REC_CYC(REC), .DROP_DLY_CYC(DLY)) i_pfwp_ctrl (
    .clk_i, .rst_ni, .pwr_good_i, .mem_sel_i, .wr_en_i, .rd_en_i,
    .mem_sel_o(a_sel), .wr_en_o(a_wr), .drive_en_o(a_drv), .sys_rst_no(a_rst)
  );

  pfwp_ctrl #(.REC_CYC(REC), .DROP_DLY_CYC(0)) i_pfwp_ctrl_nd (
    .clk_i, .rst_ni, .pwr_good_i, .mem_sel_i, .wr_en_i, .rd_en_i,
    .mem_sel_o(b_sel), .wr_en_o(b_wr), .drive_en_o(b_drv), .sys_rst_no(b_rst)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sel,wr,drv,rst} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic drive(logic s, logic w, logic r);
    @(negedge clk_i);
    mem_sel_i = s; wr_en_i = w; rd_en_i = r;
    #1;
  endtask

  function automatic logic [3:0] open_out(logic s, logic w, logic r);
    return {s, w, s & r & ~w, 1'b1};
  endfunction

  task automatic t_reset();
    mem_sel_i = 1; wr_en_i = 1; rd_en_i = 1; pwr_good_i = 1;
    edges(3);
    check("R1 reset main", {a_sel, a_wr, a_drv, a_rst}, 4'b0000);
    check("R1 reset nodly", {b_sel, b_wr, b_drv, b_rst}, 4'b0000);
    pwr_good_i = 0;
    @(negedge clk_i);
    rst_ni = 1;
    edges(4);
  endtask

  task automatic t_power_up();
    int low_seen = 0;
    @(negedge clk_i);
    pwr_good_i = 1;
    // R2: strobes ignored during the whole recovery
    for (int i = 0; i < 1 + REC; i++) begin
      @(negedge clk_i);
      mem_sel_i = i[0]; wr_en_i = i[1]; rd_en_i = i[2];
      #1;
      if (a_sel | a_wr | a_drv | a_rst) low_seen++;
    end
    n_run++;
    if (low_seen != 0) begin
      n_fail++;
      $display("FAIL R2: %0d cycles with outputs active, expected 0", low_seen);
    end
    // 1 + REC edges elapsed since change; release at edge 2 + REC (R3, R4)
    check("R4 held before release", {1'b0, 1'b0, 1'b0, a_rst}, 4'b0000);
    edges(1);
    check("R4 released main", {1'b0, 1'b0, 1'b0, a_rst}, 4'b0001);
    check("R3 released nodly", {1'b0, 1'b0, 1'b0, b_rst}, 4'b0001);
  endtask

  task automatic t_access();
    for (int p = 0; p < 8; p++) begin
      drive(p[0], p[1], p[2]);
      check("R5 access main", {a_sel, a_wr, a_drv, a_rst}, open_out(p[0], p[1], p[2]));
      check("R5 access nodly", {b_sel, b_wr, b_drv, b_rst}, open_out(p[0], p[1], p[2]));
    end
  endtask

  task automatic t_power_drop();
    drive(1, 1, 1);
    @(negedge clk_i);
    pwr_good_i = 0;
    edges(1);
    check("R3 nodly one edge", {b_sel, b_wr, b_drv, b_rst}, 4'b1101);
    edges(1);
    check("R6 R8 nodly cut", {b_sel, b_wr, b_drv, b_rst}, 4'b0000);
    edges(DLY - 1);
    check("R6 main before delay", {a_sel, a_wr, a_drv, a_rst}, 4'b1101);
    edges(1);
    check("R8 main cut at delay", {a_sel, a_wr, a_drv, a_rst}, 4'b0000);
    drive(1, 0, 1);
    check("R2 read blocked", {a_sel, a_wr, a_drv, a_rst}, 4'b0000);
  endtask

  task automatic t_short_dip();
    int hit = 0;
    drive(1, 0, 1);
    @(negedge clk_i);
    pwr_good_i = 0;
    for (int i = 0; i < DLY - 2; i++) begin
      @(negedge clk_i);
      #1;
      if (a_rst !== 1'b1) hit++;
    end
    pwr_good_i = 1;
    for (int i = 0; i < DLY + 4; i++) begin
      @(negedge clk_i);
      #1;
      if (a_rst !== 1'b1) hit++;
    end
    n_run++;
    if (hit != 0) begin
      n_fail++;
      $display("FAIL R9: protected for %0d cycles on short dip, expected 0", hit);
    end
    check("R9 access after dip", {a_sel, a_wr, a_drv, a_rst}, 4'b1011);
    check("R6 nodly reacts to dip", {1'b0, 1'b0, 1'b0, b_rst}, 4'b0000);
  endtask

  task automatic t_glitch_recovery();
    // from protected main and nodly
    @(negedge clk_i);
    pwr_good_i = 0;
    edges(2 + DLY + 2);
    @(negedge clk_i);
    pwr_good_i = 1;
    edges(REC / 2);
    @(negedge clk_i);
    pwr_good_i = 0;
    edges(2 + DLY + 3);
    check("R7 held during dip main", {1'b0, 1'b0, 1'b0, a_rst}, 4'b0000);
    check("R7 held during dip nodly", {1'b0, 1'b0, 1'b0, b_rst}, 4'b0000);
    @(negedge clk_i);
    pwr_good_i = 1;
    edges(1 + REC);
    check("R7 no early release main", {1'b0, 1'b0, 1'b0, a_rst}, 4'b0000);
    check("R7 no early release nodly", {1'b0, 1'b0, 1'b0, b_rst}, 4'b0000);
    edges(1);
    check("R7 release main", {1'b0, 1'b0, 1'b0, a_rst}, 4'b0001);
    check("R7 release nodly", {1'b0, 1'b0, 1'b0, b_rst}, 4'b0001);
    check("R5 access after recovery", {a_sel, a_wr, a_drv, a_rst}, 4'b1011);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_access();
    t_power_drop();
    t_power_up();
    t_short_dip();
    t_glitch_recovery();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule